// File: doc/BRIEF.md
# Cipher Unit Error and Mask Controller

This block is the register front end of a block-cipher accelerator. It watches host accesses on a simple register bus, the push and pop strobes of the shared input and output FIFOs with their full and empty flags, and the busy and done status of the cipher engine. From these it detects nine error conditions. Each condition sets a sticky status bit. A per-bit mask decides whether a set bit drives the interrupt output.

The block also holds the mode, key length and final-block bit count registers. It accepts key and IV words, which it checks for context but does not store, because the datapath lies elsewhere. It also decodes an end-of-message register. Writing that register, once the last 128-bit block has been pushed, gives a one-cycle start pulse. The engine then processes the final block, using as many of its bits as the bit count register gives.

Register map (word addresses): 0 mode, 1 key length in bytes, 2 final-block bit count, 3 end-of-message, 4 error status, 5 error mask, 8 to 11 IV words, 16 to 23 key words. Status and mask bit positions: 0 context, 1 key length, 2 bit count, 3 mode, 4 address, 5 output FIFO not empty, 6 input FIFO not empty, 7 input overflow, 8 output underflow.

Top module: `cipher_err_ctl`

## Requirements
- R1: A write to address 1 of any value other than 16, 24 or 32 sets status bit 1. The written value is stored and reads back.
- R2: A write to address 0, 1 or 2, to an IV address (8 to 11) or to a key address (16 to 23) while the engine-busy input is high sets status bit 0.
- R3: A write to address 2 of 0 or of any value above 128 sets status bit 2. Values 1 to 128 do not set it.
- R4: A write to address 2 while the output FIFO empty flag is low sets status bit 5.
- R5: A done pulse from the engine while the input FIFO empty flag is low sets status bit 6.
- R6: An input push while the input FIFO is full sets bit 7. An output pop while the output FIFO is empty sets bit 8.
- R7: A read or write of any address outside 0 to 5, 8 to 11 and 16 to 23 sets status bit 4 and reads as zero.
- R8: A write to address 0 sets status bit 3 when any bit above bit 1 is set or when bits [1:0] equal 3.
- R9: A write to address 3 makes final_start high for exactly the cycle after the write. Every status bit appears one cycle after its event.
- R10: A read of address 3 always returns zero.
- R11: Status bits are sticky. Writing address 4 clears the bits written as 1. A bit set and cleared in the same cycle stays set.
- R12: After reset, status is 0, the mask at address 5 is all ones and irq is low. irq is high exactly when some status bit is set whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, same cycle as bus_rd |
| in_push | input | 1 | Input FIFO push strobe |
| in_full | input | 1 | Input FIFO full flag |
| in_empty | input | 1 | Input FIFO empty flag |
| out_pop | input | 1 | Output FIFO pop strobe |
| out_empty | input | 1 | Output FIFO empty flag |
| eng_busy | input | 1 | Engine is processing |
| eng_done | input | 1 | Engine done pulse |
| irq | output | 1 | Unmasked error interrupt |
| final_start | output | 1 | One-cycle final-block start |

## Verification
The assertions assume that bus_wr and bus_rd are never high together. They also assume that the FIFO flags and the engine status are valid in every cycle, with no protocol between them. The random stimulus draws exactly one bus operation, a read or a write, per cycle. It draws the flags and strobes on their own, so it reaches combinations a real FIFO would never produce, such as full and empty together. The design must still classify each of those combinations independently.

// File: rtl/cipher_err_ctl.sv
module cipher_err_ctl #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int IV_BASE   = 8,
  parameter int IV_WORDS  = 4,
  parameter int KEY_BASE  = 16,
  parameter int KEY_WORDS = 8,
  parameter int MAX_BITS  = 128,
  parameter int MODE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              in_push,
  input  logic              in_full,
  input  logic              in_empty,
  input  logic              out_pop,
  input  logic              out_empty,
  input  logic              eng_busy,
  input  logic              eng_done,
  output logic              irq,
  output logic              final_start
);
  localparam int NERR = 9;
  localparam int E_CTX = 0, E_KSZ = 1, E_DSZ = 2, E_MODE = 3, E_ADDR = 4,
                 E_OFE = 5, E_IFE = 6, E_OVF = 7, E_UNF = 8;
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_KSZ  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DSZ  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EOM  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] IV_LO  = ADDR_W'(IV_BASE);
  localparam logic [ADDR_W-1:0] IV_HI  = ADDR_W'(IV_BASE + IV_WORDS - 1);
  localparam logic [ADDR_W-1:0] KEY_LO = ADDR_W'(KEY_BASE);
  localparam logic [ADDR_W-1:0] KEY_HI = ADDR_W'(KEY_BASE + KEY_WORDS - 1);
  localparam logic [MODE_W-1:0] MODE_BAD = '1;

  logic [DATA_W-1:0] mode_q, ksize_q, dsize_q;
  logic [NERR-1:0]   status_q, mask_q, err_set, clr;

  wire in_iv   = (bus_addr >= IV_LO) && (bus_addr <= IV_HI);
  wire in_key  = (bus_addr >= KEY_LO) && (bus_addr <= KEY_HI);
  wire mapped  = in_iv || in_key || (bus_addr <= A_MASK);
  wire ctx_reg = in_iv || in_key || bus_addr == A_MODE || bus_addr == A_KSZ || bus_addr == A_DSZ;
  wire wr_ksz  = bus_wr && bus_addr == A_KSZ;
  wire wr_dsz  = bus_wr && bus_addr == A_DSZ;
  wire wr_mode = bus_wr && bus_addr == A_MODE;

  wire ksz_ok  = bus_wdata == DATA_W'(16) || bus_wdata == DATA_W'(24) || bus_wdata == DATA_W'(32);
  wire dsz_bad = bus_wdata == '0 || bus_wdata > DATA_W'(MAX_BITS);
  wire mode_bad = (bus_wdata >> MODE_W) != '0 || bus_wdata[MODE_W-1:0] == MODE_BAD;

  assign err_set[E_CTX]  = bus_wr && ctx_reg && eng_busy;
  assign err_set[E_KSZ]  = wr_ksz && !ksz_ok;
  assign err_set[E_DSZ]  = wr_dsz && dsz_bad;
  assign err_set[E_MODE] = wr_mode && mode_bad;
  assign err_set[E_ADDR] = (bus_wr || bus_rd) && !mapped;
  assign err_set[E_OFE]  = wr_dsz && !out_empty;
  assign err_set[E_IFE]  = eng_done && !in_empty;
  assign err_set[E_OVF]  = in_push && in_full;
  assign err_set[E_UNF]  = out_pop && out_empty;

  assign clr = (bus_wr && bus_addr == A_STAT) ? bus_wdata[NERR-1:0] : '0;
  assign irq = |(status_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q    <= '0;
      mask_q      <= '1;
      mode_q      <= '0;
      ksize_q     <= '0;
      dsize_q     <= '0;
      final_start <= 1'b0;
    end else begin
      status_q    <= (status_q & ~clr) | err_set;
      final_start <= bus_wr && bus_addr == A_EOM;
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[NERR-1:0];
      if (wr_mode) mode_q  <= bus_wdata;
      if (wr_ksz)  ksize_q <= bus_wdata;
      if (wr_dsz)  dsize_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_MODE:  bus_rdata = mode_q;
        A_KSZ:   bus_rdata = ksize_q;
        A_DSZ:   bus_rdata = dsize_q;
        A_STAT:  bus_rdata = DATA_W'(status_q);
        A_MASK:  bus_rdata = DATA_W'(mask_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  a_r1_bad_keylen: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_KSZ && bus_wdata != DATA_W'(16) && bus_wdata != DATA_W'(24)
     && bus_wdata != DATA_W'(32)) |=> status_q[E_KSZ]);
  a_r2_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && eng_busy && bus_addr == A_MODE) |=> status_q[E_CTX]);
  a_r6_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_push && in_full) |=> status_q[E_OVF]);
  a_r9_start_once: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EOM) |=> final_start);
  a_r9_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_EOM) |=> !final_start);
  a_r10_eom_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_EOM) |-> bus_rdata == '0);
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_STAT) |=> (status_q & $past(status_q)) == $past(status_q));
  a_r12_mask_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (mask_q == '1 && !irq));
endmodule

// File: tb/tb_cipher_err_ctl.sv
`timescale 1ns/1ps
module tb_cipher_err_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        in_push = 0, in_full = 0, in_empty = 1, out_pop = 0, out_empty = 1;
  logic        eng_busy = 0, eng_done = 0;
  logic        irq, final_start;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [8:0]  m_status = '0, m_mask = '1;
  logic [31:0] m_mode = '0, m_ks = '0, m_ds = '0;

  always #2 clk = ~clk;

  cipher_err_ctl dut (.*);

  function automatic bit is_mapped(input logic [4:0] a);
    return (a <= 5) || (a >= 8 && a <= 11) || (a >= 16 && a <= 23);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    case (a)
      5'd0: return m_mode;
      5'd1: return m_ks;
      5'd2: return m_ds;
      5'd4: return {23'd0, m_status};
      5'd5: return {23'd0, m_mask};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [8:0] exp_set(input logic wr, rd, input logic [4:0] a,
      input logic [31:0] d, input logic ip, ifl, ie, op, oe, bsy, dn);
    logic [8:0] s = '0;
    bit ctx = (a <= 2) || (a >= 8 && a <= 11) || (a >= 16 && a <= 23);
    if ((wr || rd) && !is_mapped(a)) s[4] = 1;
    if (wr && ctx && bsy) s[0] = 1;
    if (wr && a == 1 && !(d == 16 || d == 24 || d == 32)) s[1] = 1;
    if (wr && a == 2 && (d == 0 || d > 128)) s[2] = 1;
    if (wr && a == 2 && !oe) s[5] = 1;
    if (wr && a == 0 && ((d >> 2) != 0 || d[1:0] == 2'd3)) s[3] = 1;
    if (dn && !ie) s[6] = 1;
    if (ip && ifl) s[7] = 1;
    if (op && oe) s[8] = 1;
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic op(input logic wr, rd, input logic [4:0] a, input logic [31:0] d,
      input logic ip, ifl, ie, opp, oe, bsy, dn, input string tag);
    logic [8:0] s;
    logic [8:0] clr;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    in_push = ip; in_full = ifl; in_empty = ie; out_pop = opp; out_empty = oe;
    eng_busy = bsy; eng_done = dn;
    #1;
    if (rd) chk(tag, bus_rdata, exp_rd(a));
    s = exp_set(wr, rd, a, d, ip, ifl, ie, opp, oe, bsy, dn);
    clr = (wr && a == 4) ? d[8:0] : '0;
    @(posedge clk); #1;
    m_status = (m_status & ~clr) | s;
    if (wr && a == 5) m_mask = d[8:0];
    if (wr && a == 0) m_mode = d;
    if (wr && a == 1) m_ks = d;
    if (wr && a == 2) m_ds = d;
    chk("R9", {31'd0, final_start}, {31'd0, wr && a == 5'd3});
    chk("R12", {31'd0, irq}, {31'd0, |(m_status & ~m_mask)});
    bus_wr = 0; bus_rd = 0; in_push = 0; out_pop = 0; eng_done = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    op(1, 0, a, d, 0, 0, 1, 0, 1, 0, 0, tag);
  endtask
  task automatic rd(input logic [4:0] a, input string tag);
    op(0, 1, a, 0, 0, 0, 1, 0, 1, 0, 0, tag);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R12", {31'd0, irq}, 32'd0);
    chk("R9", {31'd0, final_start}, 32'd0);
    rd(5, "R12"); rd(4, "R12");
    // R1
    wr(1, 20, "R1"); rd(4, "R1"); rd(1, "R1");
    wr(4, 9'h1FF, "R11"); wr(1, 24, "R1"); rd(4, "R1");
    // R2
    op(1, 0, 9, 32'hABCD, 0, 0, 1, 0, 1, 1, 0, "R2"); rd(4, "R2");
    // R3
    wr(4, 9'h1FF, "R11"); wr(2, 0, "R3"); rd(4, "R3");
    wr(4, 9'h1FF, "R11"); wr(2, 129, "R3"); rd(4, "R3");
    wr(4, 9'h1FF, "R11"); wr(2, 128, "R3"); rd(4, "R3"); rd(2, "R9");
    wr(2, 1, "R3"); rd(4, "R3");
    // R4
    op(1, 0, 2, 64, 0, 0, 1, 0, 0, 0, 0, "R4"); rd(4, "R4");
    // R5
    op(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, "R5"); rd(4, "R5");
    // R6
    wr(4, 9'h1FF, "R11");
    op(0, 0, 0, 0, 1, 1, 1, 0, 1, 0, 0, "R6");
    op(0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, "R6"); rd(4, "R6");
    // R7
    wr(4, 9'h1FF, "R11"); rd(6, "R7"); rd(4, "R7");
    wr(4, 9'h1FF, "R11"); wr(31, 5, "R7"); rd(4, "R7");
    // R8
    wr(4, 9'h1FF, "R11"); wr(0, 3, "R8"); rd(4, "R8");
    wr(4, 9'h1FF, "R11"); wr(0, 4, "R8"); rd(4, "R8");
    wr(4, 9'h1FF, "R11"); wr(0, 2, "R8"); rd(4, "R8"); rd(0, "R8");
    // R9 / R10
    wr(3, 32'hFFFF, "R9"); rd(3, "R10");
    // R11: set wins over clear
    op(0, 0, 0, 0, 1, 1, 1, 0, 1, 0, 0, "R11");
    op(1, 0, 4, 9'h080, 1, 1, 1, 0, 1, 0, 0, "R11"); rd(4, "R11");
    // R12: unmask overflow only
    wr(5, 9'h17F, "R12"); rd(5, "R12"); rd(4, "R12");
    wr(4, 9'h1FF, "R12");
    // random
    for (int i = 0; i < 400; i++) begin
      logic [4:0] a = 5'($urandom_range(0, 31));
      logic w = 1'($urandom_range(0, 1));
      logic [31:0] d;
      case ($urandom_range(0, 4))
        0: d = 32'($urandom_range(0, 140));
        1: d = 32'd8 * 32'($urandom_range(1, 5));
        2: d = 32'($urandom_range(0, 7));
        3: d = 32'($urandom_range(0, 511));
        default: d = $urandom;
      endcase
      op(w, !w, a, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
         1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
         1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0), "R11");
      rd(4, "R11");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule